// File: doc/BRIEF.md
# Bus Abort Detector with Fault Status Capture

This block watches every access on a 32-bit internal bus that two masters share. Each access is checked in the same cycle it is presented. A data access whose address does not fit its size is rejected. So is any access that the address decoder has flagged as falling in unmapped space. A rejected access is not forwarded to the memory side. Instead, an abort strobe goes back to the master that issued it.

On every abort the block records the full requested address, together with the size, the kind of access, the cause or causes, and which master was responsible. Each master also has a sticky flag. The flag sets when that master is aborted and clears when software reads the status word. Software reads the captured state through a small read-only register port at word offsets.

Top module: `bus_abort_top`

## Requirements
- R1: A word access (size code 2'b10) whose address bits [1:0] are not 2'b00 is aborted in the same cycle, and its forward strobe stays low.
- R2: A halfword access (size code 2'b01) with address bit 0 set is aborted in the same cycle. A halfword access at an even address passes.
- R3: A byte access (size code 2'b00) is never misaligned, whatever its address.
- R4: An instruction fetch (type code 2'b10) is never checked for alignment. Type 2'b00 is a data read and 2'b01 is a data write.
- R5: An access flagged as unmapped by the decoder input is aborted, whatever its size, type or alignment.
- R6: An abort goes only to the requesting master, on bit `reqMaster` of `abortOut`. At most one abort bit is high, and `fwdValid` is low whenever an abort is raised.
- R7: On each abort, the full 32-bit address is latched into the address register at offset 0x08. That register is visible on the edge after the abort.
- R8: On each abort, the status word at offset 0x04 records the size in bits [1:0] and the type in bits [3:2].
- R9: Status bit 8 holds the unmapped cause and bit 9 holds the misaligned cause. Both bits may be set together. A fetch never sets bit 9.
- R10: Status bits [17:16] hold a one-hot code for the master of the most recent abort.
- R11: Status bits [25:24] are sticky per-master abort flags. A status read clears them on the following edge. An abort in that same cycle leaves its own flag set.
- R12: After reset, both the status word and the address register read as zero. Offset 0x00 and any unused offset read as zero.
- R13: An access that is not aborted leaves both captured registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access presented this cycle |
| reqMaster | input | 1 | Index of the issuing master |
| reqAddr | input | 32 | Requested byte address |
| reqSize | input | 2 | 00 byte, 01 halfword, 10 word |
| reqType | input | 2 | 00 data read, 01 data write, 10 code fetch |
| reqUnmapped | input | 1 | Decoder flag: address hits no target |
| fwdValid | output | 1 | Access forwarded to the memory side |
| abortOut | output | 2 | Abort strobe, one bit per master |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 4 | Register byte offset |
| regRdData | output | 32 | Read data, combinational from current state |

## Verification
The bench targets the alignment corners that are most often got wrong. A word access at offsets 1, 2 and 3 must abort. A halfword access at an odd address must abort while one at offset 2 passes. Byte accesses at odd addresses must pass. A misaligned fetch must pass, but an unmapped fetch must still abort. A design that checked fetches would abort legal code. A design that tested the wrong address bits would abort aligned halfwords or pass bad words.

The bench also sets up a status read and a new abort in the same cycle. A design that let the clear win would lose that abort's sticky flag. A design that ignored the clear would report stale flags. Finally, the bench checks that passing accesses leave the captured address alone. A design that captured on every access would report the wrong faulting address.

// File: rtl/bus_abort_pkg.sv
package bus_abort_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] TY_READ  = 2'b00;
  localparam logic [1:0] TY_WRITE = 2'b01;
  localparam logic [1:0] TY_FETCH = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic misal;
    logic unmapped;
    logic clrSticky;
  } strobe_t;
endpackage

// File: rtl/bus_abort_ctrl.sv
module bus_abort_ctrl
  import bus_abort_pkg::*;
#(
  parameter int NMST   = 2,
  parameter int REG_AW = 4,
  parameter logic [REG_AW-1:0] OFF_STATUS = 4'h4,
  localparam int MST_W = (NMST > 1) ? $clog2(NMST) : 1
) (
  input  logic              reqValid,
  input  logic [MST_W-1:0]  reqMaster,
  input  logic [1:0]        addrLow,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqType,
  input  logic              reqUnmapped,
  input  logic              regRd,
  input  logic [REG_AW-1:0] regAddr,
  output logic              fwdValid,
  output logic [NMST-1:0]   abortVec,
  output strobe_t           strobe
);
  logic misal;
  logic fail;

  always_comb begin
    misal = 1'b0;
    if (reqType != TY_FETCH) begin
      unique case (reqSize)
        SZ_WORD: misal = (addrLow != 2'b00);
        SZ_HALF: misal = addrLow[0];
        default: misal = 1'b0;
      endcase
    end
  end

  assign fail     = reqValid && (misal || reqUnmapped);
  assign fwdValid = reqValid && !fail;

  generate
    for (genvar m = 0; m < NMST; m++) begin : g_abort
      assign abortVec[m] = fail && (reqMaster == MST_W'(m));
    end
  endgenerate

  assign strobe.capture   = fail;
  assign strobe.misal     = misal;
  assign strobe.unmapped  = reqUnmapped;
  assign strobe.clrSticky = regRd && (regAddr == OFF_STATUS);
endmodule

// File: rtl/bus_abort_dp.sv
module bus_abort_dp
  import bus_abort_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NMST   = 2,
  parameter int REG_AW = 4,
  parameter logic [REG_AW-1:0] OFF_STATUS = 4'h4,
  parameter logic [REG_AW-1:0] OFF_ADDR   = 4'h8,
  localparam int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [NMST-1:0]   abortVec,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqType,
  input  logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] statusWord,
  output logic [ADDR_W-1:0] addrWord,
  output logic [DATA_W-1:0] regRdData
);
  logic [1:0]      sizeQ, typeQ;
  logic            misalQ, unmappedQ;
  logic [NMST-1:0] mstQ, stickyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrWord  <= '0;
      sizeQ     <= '0;
      typeQ     <= '0;
      misalQ    <= 1'b0;
      unmappedQ <= 1'b0;
      mstQ      <= '0;
    end else if (strobe.capture) begin
      addrWord  <= reqAddr;
      sizeQ     <= reqSize;
      typeQ     <= reqType;
      misalQ    <= strobe.misal;
      unmappedQ <= strobe.unmapped;
      mstQ      <= abortVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 stickyQ <= '0;
    else if (strobe.clrSticky) stickyQ <= abortVec;
    else                       stickyQ <= stickyQ | abortVec;
  end

  always_comb begin
    statusWord        = '0;
    statusWord[1:0]   = sizeQ;
    statusWord[3:2]   = typeQ;
    statusWord[8]     = unmappedQ;
    statusWord[9]     = misalQ;
    statusWord[16 +: NMST] = mstQ;
    statusWord[24 +: NMST] = stickyQ;
  end

  always_comb begin
    if (regAddr == OFF_STATUS)    regRdData = statusWord;
    else if (regAddr == OFF_ADDR) regRdData = DATA_W'(addrWord);
    else                          regRdData = '0;
  end
endmodule

// File: rtl/bus_abort_top.sv
module bus_abort_top
  import bus_abort_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NMST   = 2,
  parameter int REG_AW = 4,
  localparam int MST_W = (NMST > 1) ? $clog2(NMST) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MST_W-1:0]  reqMaster,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqType,
  input  logic              reqUnmapped,
  output logic              fwdValid,
  output logic [NMST-1:0]   abortOut,
  input  logic              regRd,
  input  logic [REG_AW-1:0] regAddr,
  output logic [31:0]       regRdData
);
  localparam logic [REG_AW-1:0] OFF_STATUS = REG_AW'(4);
  localparam logic [REG_AW-1:0] OFF_ADDR   = REG_AW'(8);

  strobe_t           strobe;
  logic [31:0]       statusWord;
  logic [ADDR_W-1:0] addrWord;

  bus_abort_ctrl #(.NMST(NMST), .REG_AW(REG_AW), .OFF_STATUS(OFF_STATUS)) ctrl_i (
    .reqValid(reqValid), .reqMaster(reqMaster), .addrLow(reqAddr[1:0]),
    .reqSize(reqSize), .reqType(reqType), .reqUnmapped(reqUnmapped),
    .regRd(regRd), .regAddr(regAddr), .fwdValid(fwdValid),
    .abortVec(abortOut), .strobe(strobe)
  );

  bus_abort_dp #(.ADDR_W(ADDR_W), .NMST(NMST), .REG_AW(REG_AW),
                 .OFF_STATUS(OFF_STATUS), .OFF_ADDR(OFF_ADDR)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .abortVec(abortOut),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqType(reqType),
    .regAddr(regAddr), .statusWord(statusWord), .addrWord(addrWord),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/bus_abort_chk.sv
module bus_abort_chk #(
  parameter int ADDR_W = 32,
  parameter int NMST   = 2,
  parameter int MST_W  = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [MST_W-1:0]  reqMaster,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqType,
  input logic              reqUnmapped,
  input logic              fwdValid,
  input logic [NMST-1:0]   abortOut,
  input logic [31:0]       statusWord,
  input logic [ADDR_W-1:0] addrWord
);
  p_fetch_exempt_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqType == 2'b10 && !reqUnmapped) |-> (abortOut == '0));

  p_unmapped_abort_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqUnmapped) |-> (abortOut != '0));

  p_single_abort_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(abortOut));

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rstN)
    (abortOut != '0) |-> !fwdValid);

  p_addr_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    (abortOut != '0) |=> (addrWord == $past(reqAddr)));

  p_master_id_r10: assert property (@(posedge clk) disable iff (!rstN)
    (abortOut != '0) |=> (statusWord[16 +: NMST] == $past(abortOut)));

  p_sticky_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    (abortOut != '0) |=> ((statusWord[24 +: NMST] & $past(abortOut)) == $past(abortOut)));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && abortOut == '0) |=> $stable(addrWord));
endmodule

bind bus_abort_top bus_abort_chk #(.ADDR_W(ADDR_W), .NMST(NMST), .MST_W(MST_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMaster(reqMaster),
  .reqAddr(reqAddr), .reqType(reqType), .reqUnmapped(reqUnmapped),
  .fwdValid(fwdValid), .abortOut(abortOut), .statusWord(statusWord),
  .addrWord(addrWord)
);

// File: tb/bus_abort_top_tb_top.sv
`timescale 1ns/1ps
module bus_abort_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqMaster = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0] reqSize = '0, reqType = '0;
  logic reqUnmapped = 1'b0;
  logic fwdValid;
  logic [1:0] abortOut;
  logic regRd = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regRdData;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_abort_top dut_i (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [1:0]  kind;
    logic        unm;
    logic        mst;
    logic        expAbort;
    logic        expMisal;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 aligned word
    '{32'h0000_1001, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1}, // R1
    '{32'h0000_1002, 2'b10, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1}, // R1
    '{32'h0000_1003, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1}, // R1
    '{32'h0000_2002, 2'b01, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 aligned half
    '{32'h0000_2003, 2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1}, // R2
    '{32'h0000_3003, 2'b00, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 byte
    '{32'h0000_4002, 2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 fetch exempt
    '{32'h0000_4001, 2'b01, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    '{32'h0000_5000, 2'b10, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 unmapped
    '{32'h0000_5001, 2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 unmapped fetch
    '{32'h0000_6001, 2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1}  // R9 both causes
  };

  // Bench model of captured state
  logic [31:0] mAddr = '0;
  logic [1:0]  mSize = '0, mType = '0, mMst = '0, mSticky = '0;
  logic        mMisal = 1'b0, mUnm = 1'b0;

  function automatic logic [31:0] mStatus();
    logic [31:0] s = '0;
    s[1:0] = mSize; s[3:2] = mType; s[8] = mUnm; s[9] = mMisal;
    s[17:16] = mMst; s[25:24] = mSticky;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [3:0] off, input string req, input logic [31:0] exp);
    @(negedge clk);
    reqValid = 1'b0; regRd = 1'b1; regAddr = off;
    #1 chk(req, regRdData, exp);
    @(posedge clk);
    if (off == 4'h4) mSticky = '0;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    regRd = 1'b0;
    reqValid = 1'b1; reqAddr = v.addr; reqSize = v.size;
    reqType = v.kind; reqUnmapped = v.unm; reqMaster = v.mst;
  endtask

  task automatic modelAbort(input vec_t v);
    mAddr = v.addr; mSize = v.size; mType = v.kind; mUnm = v.unm;
    mMisal = v.expMisal; mMst = v.mst ? 2'b10 : 2'b01;
    mSticky = mSticky | mMst;
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state and map
    doRead(4'h4, "R12 status reset", 32'h0);
    doRead(4'h8, "R12 addr reset", 32'h0);
    doRead(4'h0, "R12 offset 0", 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      #1;
      chk("R6 abortOut", {30'h0, abortOut},
          VECS[i].expAbort ? (VECS[i].mst ? 32'd2 : 32'd1) : 32'd0);
      chk("R1-R5 fwdValid", {31'h0, fwdValid}, {31'h0, !VECS[i].expAbort});
      @(posedge clk);
      if (VECS[i].expAbort) modelAbort(VECS[i]);
      doRead(4'h8, VECS[i].expAbort ? "R7 addr" : "R13 addr hold", mAddr);
      doRead(4'h4, "R8 R9 R10 status", mStatus());
    end

    // R11 accumulation from both masters
    drive('{32'h0000_7001, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1});
    @(posedge clk); modelAbort('{32'h0000_7001, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1});
    drive('{32'h0000_7003, 2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1});
    @(posedge clk); modelAbort('{32'h0000_7003, 2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1});
    doRead(4'h4, "R11 both sticky", mStatus());
    chk("R11 sticky after read", 32'(mSticky), 32'h0);

    // R11 read and abort in the same cycle
    drive('{32'h0000_8002, 2'b10, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1});
    @(posedge clk); modelAbort('{32'h0000_8002, 2'b10, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1});
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h0000_8101; reqSize = 2'b01;
    reqType = 2'b00; reqUnmapped = 1'b0; reqMaster = 1'b1;
    regRd = 1'b1; regAddr = 4'h4;
    #1 chk("R11 read sees m0 sticky", regRdData, mStatus());
    @(posedge clk);
    mAddr = 32'h0000_8101; mSize = 2'b01; mType = 2'b00; mUnm = 1'b0;
    mMisal = 1'b1; mMst = 2'b10; mSticky = 2'b10;
    doRead(4'h4, "R11 same-cycle abort kept", mStatus());

    // R13 passing traffic leaves status alone
    drive('{32'h0000_9004, 2'b10, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0});
    @(posedge clk);
    doRead(4'h4, "R13 status hold", mStatus());

    // R12 reset clears captured state
    @(negedge clk); reqValid = 1'b0; rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    doRead(4'h8, "R12 addr after reset", 32'h0);
    doRead(4'h4, "R12 status after reset", 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule